// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block holds two alarm settings and compares each against the running calendar time. The calendar time arrives as seven BCD bytes: seconds, minutes, hours, day of month, month, year and weekday. Each alarm stores one byte per field together with a per-field enable. An alarm matches when every enabled field equals the matching time field. A setting with no enabled field never matches. The most significant bit of the hour byte selects 12- or 24-hour format, so the hour comparison leaves that bit out.

The choice of enabled fields sets how often an alarm repeats. Weekday, hour and minute give an alarm once a week. Hour and minute alone give one every day. Month, day, hour and minute give one every year. The match is taken only on the once-per-second tick. Each alarm has a sticky status flag that sets when its match goes from false to true, and a write to the status port clears it. Software loads the alarm settings one field at a time through a plain write port.

Top module: `cal_alarm_match`

## Requirements
- R1: The two alarm settings are independent. A write with `alm_wr_sel`=0 changes only alarm 0, and a write with `alm_wr_sel`=1 changes only alarm 1. Output bit n belongs to alarm n.
- R2: Each field has its own enable bit, and only enabled fields take part in the match. An alarm whose enables are all clear never matches. Field index encoding: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 weekday. Byte k of `time_now` is bits [8k+7:8k]. A write to field index 7 is ignored.
- R3: The hour comparison ignores bit 7 of the hour byte, which is the 12/24-hour select.
- R4: An alarm with only weekday, hour and minute enabled matches on that weekday at that hour and minute, whatever the date.
- R5: An alarm with only hour and minute enabled matches at that time on any day.
- R6: An alarm with month, day, hour and minute enabled matches only on that month and day, at that hour and minute.
- R7: The match is evaluated only in a cycle where `sec_tick` is high. `alarm_match` shows the latest result one cycle after the tick and holds it until the next tick.
- R8: `alarm_status[n]` sets one cycle after a tick where alarm n matches and the previous evaluation did not. A match that continues over further ticks does not set it again.
- R9: A cycle with `stat_wr` high clears each status bit whose `stat_clr` bit is 1 and leaves the other status bits alone. If a set and a clear fall in the same cycle, the set wins.
- R10: After reset, every stored value and enable is zero, and `alarm_match` and `alarm_status` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| time_now | input | 56 | Current BCD time, seven bytes, byte k = field k |
| alm_wr | input | 1 | Alarm field write strobe |
| alm_wr_sel | input | 1 | Alarm number to write |
| alm_wr_field | input | 3 | Field index to write |
| alm_wr_value | input | 8 | BCD compare value for the field |
| alm_wr_enable | input | 1 | Enable bit for the field |
| stat_wr | input | 1 | Status write strobe |
| stat_clr | input | 2 | Per-alarm clear mask used with `stat_wr` |
| alarm_match | output | 2 | Registered match result from the latest tick |
| alarm_status | output | 2 | Sticky alarm flags |

## Verification
A field write takes effect at the clock edge that samples it, and the comparison is combinational. A time or setting change therefore shows at the outputs exactly one cycle after the next tick, when `alarm_match` and `alarm_status` update together. The bench drives every input on the falling edge, holds the tick for one cycle, and samples on the following falling edge, which is that single registered cycle. The checks for no tick, for clearing, and for a set and a clear in the same cycle sample in that same cycle, so any change made one cycle early or late shows up.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
    localparam int NUM_FIELDS  = 7;
    localparam int FIELD_IDX_W = 3;

    typedef enum logic [FIELD_IDX_W-1:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_DAY  = 3'd3,
        FLD_MON  = 3'd4,
        FLD_YEAR = 3'd5,
        FLD_WDAY = 3'd6
    } field_e;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [FIELD_IDX_W-1:0]        wr_field,
    input  logic [FIELD_W-1:0]            wr_value,
    input  logic                          wr_enable,
    output logic [NUM_FIELDS*FIELD_W-1:0] val_flat,
    output logic [NUM_FIELDS-1:0]         en_bits
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] val_d, val_q;
    logic [NUM_FIELDS-1:0]              en_d, en_q;

    always_comb begin
        val_d = val_q;
        en_d  = en_q;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (wr_en && wr_field == FIELD_IDX_W'(i)) begin
                val_d[i] = wr_value;
                en_d[i]  = wr_enable;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            en_q  <= '0;
        end else begin
            val_q <= val_d;
            en_q  <= en_d;
        end
    end

    assign val_flat = val_q;
    assign en_bits  = en_q;

    // R10: storage is empty right after reset
    a_r10_regs_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> en_q == '0);
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_alarm_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0] time_flat,
    input  logic [NUM_FIELDS*FIELD_W-1:0] val_flat,
    input  logic [NUM_FIELDS-1:0]         en_bits,
    output logic                          match
);
    localparam logic [FIELD_W-1:0] FULL_MASK = '1;
    localparam logic [FIELD_W-1:0] HOUR_MASK = FULL_MASK >> 1;

    logic [NUM_FIELDS-1:0] field_ok;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam logic [FIELD_W-1:0] MASK =
            (f == int'(FLD_HOUR)) ? HOUR_MASK : FULL_MASK;
        logic [FIELD_W-1:0] diff;
        assign diff        = (time_flat[f*FIELD_W +: FIELD_W]
                            ^ val_flat[f*FIELD_W +: FIELD_W]) & MASK;
        assign field_ok[f] = !en_bits[f] || (diff == '0);
    end

    assign match = (|en_bits) && (&field_ok);
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter int NUM_ALARMS = 2,
    parameter int FIELD_W    = 8,
    localparam int SEL_W     = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1,
    localparam int TIME_W    = NUM_FIELDS * FIELD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sec_tick,
    input  logic [TIME_W-1:0]      time_now,
    input  logic                   alm_wr,
    input  logic [SEL_W-1:0]       alm_wr_sel,
    input  logic [FIELD_IDX_W-1:0] alm_wr_field,
    input  logic [FIELD_W-1:0]     alm_wr_value,
    input  logic                   alm_wr_enable,
    input  logic                   stat_wr,
    input  logic [NUM_ALARMS-1:0]  stat_clr,
    output logic [NUM_ALARMS-1:0]  alarm_match,
    output logic [NUM_ALARMS-1:0]  alarm_status
);
    typedef struct packed {
        logic [NUM_ALARMS-1:0] match;
        logic [NUM_ALARMS-1:0] status;
    } flag_state_t;

    flag_state_t            st_d, st_q;
    logic [NUM_ALARMS-1:0]  cur_match;

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        logic [TIME_W-1:0]     val_flat;
        logic [NUM_FIELDS-1:0] en_bits;
        logic                  sel_hit;

        assign sel_hit = alm_wr && (alm_wr_sel == SEL_W'(a));

        cal_alarm_regs #(.FIELD_W(FIELD_W)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sel_hit),
            .wr_field  (alm_wr_field),
            .wr_value  (alm_wr_value),
            .wr_enable (alm_wr_enable),
            .val_flat  (val_flat),
            .en_bits   (en_bits)
        );

        cal_alarm_cmp #(.FIELD_W(FIELD_W)) u_cmp (
            .time_flat (time_now),
            .val_flat  (val_flat),
            .en_bits   (en_bits),
            .match     (cur_match[a])
        );

        // R2: no enabled field means no match
        a_r2_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
            (en_bits == '0) |-> !cur_match[a]);
        // R8: a fresh match at a tick raises the flag next cycle
        a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (sec_tick && cur_match[a] && !alarm_match[a]) |=> alarm_status[a]);
        // R8: the flag rises only right after a tick
        a_r8_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alarm_status[a]) |-> $past(sec_tick));
        // R9: a clear with no competing set drops the flag
        a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr && stat_clr[a] && !sec_tick) |=> !alarm_status[a]);
    end

    always_comb begin
        st_d = st_q;
        if (stat_wr) begin
            st_d.status = st_q.status & ~stat_clr;
        end
        if (sec_tick) begin
            st_d.match  = cur_match;
            st_d.status = st_d.status | (cur_match & ~st_q.match);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_match  = st_q.match;
    assign alarm_status = st_q.status;

    // R7: without a tick the match output holds
    a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(alarm_match));
endmodule

// File: tb/cal_alarm_match_test.sv
module cal_alarm_match_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [55:0] time_now = '0;
    logic        alm_wr = 1'b0;
    logic [0:0]  alm_wr_sel = '0;
    logic [2:0]  alm_wr_field = '0;
    logic [7:0]  alm_wr_value = '0;
    logic        alm_wr_enable = 1'b0;
    logic        stat_wr = 1'b0;
    logic [1:0]  stat_clr = '0;
    logic [1:0]  alarm_match;
    logic [1:0]  alarm_status;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    cal_alarm_match uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .time_now(time_now),
        .alm_wr(alm_wr), .alm_wr_sel(alm_wr_sel), .alm_wr_field(alm_wr_field),
        .alm_wr_value(alm_wr_value), .alm_wr_enable(alm_wr_enable),
        .stat_wr(stat_wr), .stat_clr(stat_clr),
        .alarm_match(alarm_match), .alarm_status(alarm_status)
    );

    // {weekday, year, month, day, hour, min, sec, expected match[1:0]}
    // alarm 0: weekday 3, 08:00 ; alarm 1: 21:30 daily
    localparam int NVEC = 8;
    localparam logic [57:0] VEC [NVEC] = '{
        {8'h03, 8'h24, 8'h05, 8'h15, 8'h08, 8'h00, 8'h10, 2'b01},
        {8'h04, 8'h24, 8'h05, 8'h16, 8'h08, 8'h00, 8'h00, 2'b00},
        {8'h03, 8'h24, 8'h05, 8'h15, 8'h09, 8'h00, 8'h00, 2'b00},
        {8'h03, 8'h24, 8'h05, 8'h22, 8'h88, 8'h00, 8'h00, 2'b01},
        {8'h01, 8'h24, 8'h05, 8'h13, 8'h21, 8'h30, 8'h00, 2'b10},
        {8'h05, 8'h25, 8'h11, 8'h02, 8'h21, 8'h30, 8'h45, 2'b10},
        {8'h05, 8'h25, 8'h11, 8'h02, 8'hA1, 8'h30, 8'h00, 2'b10},
        {8'h03, 8'h24, 8'h05, 8'h15, 8'h21, 8'h31, 8'h00, 2'b00}
    };

    task automatic check2(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr_field(input logic sel, input logic [2:0] fld,
                            input logic [7:0] val, input logic en);
        alm_wr = 1'b1; alm_wr_sel = sel; alm_wr_field = fld;
        alm_wr_value = val; alm_wr_enable = en;
        @(negedge clk);
        alm_wr = 1'b0;
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic clear_all();
        stat_wr = 1'b1; stat_clr = 2'b11;
        @(negedge clk);
        stat_wr = 1'b0; stat_clr = 2'b00;
    endtask

    function automatic logic [55:0] tm(input logic [7:0] wd, yr, mo, dy, hr, mi, se);
        return {wd, yr, mo, dy, hr, mi, se};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state, and no match with nothing enabled (R2)
        check2("R10 match after reset", alarm_match, 2'b00);
        check2("R10 status after reset", alarm_status, 2'b00);
        time_now = '0;
        tick();
        check2("R2 empty alarm never matches", alarm_match, 2'b00);

        // alarm 0 weekly (R4), alarm 1 daily (R5)
        wr_field(1'b0, 3'd6, 8'h03, 1'b1);
        wr_field(1'b0, 3'd2, 8'h08, 1'b1);
        wr_field(1'b0, 3'd1, 8'h00, 1'b1);
        wr_field(1'b0, 3'd0, 8'h59, 1'b0);
        wr_field(1'b1, 3'd2, 8'h21, 1'b1);
        wr_field(1'b1, 3'd1, 8'h30, 1'b1);
        wr_field(1'b0, 3'd7, 8'hFF, 1'b1); // R2: index 7 ignored

        // vector walk: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            time_now = VEC[i][57:2];
            tick();
            check2($sformatf("R4/R5/R3 vector %0d", i), alarm_match, VEC[i][1:0]);
        end

        // R8: rising edge only
        clear_all();
        time_now = tm(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        tick();
        clear_all();
        time_now = tm(8'h02, 8'h24, 8'h06, 8'h01, 8'h21, 8'h30, 8'h00);
        tick();
        check2("R8 set on new match", alarm_status, 2'b10);
        clear_all();
        check2("R9 clear both", alarm_status, 2'b00);
        tick();
        check2("R8 no re-set while match persists", alarm_status, 2'b00);

        // R7: no tick means no evaluation
        time_now = tm(8'h03, 8'h24, 8'h06, 8'h05, 8'h08, 8'h00, 8'h00);
        @(negedge clk);
        @(negedge clk);
        check2("R7 match held without tick", alarm_match, 2'b10);
        check2("R7 status held without tick", alarm_status, 2'b00);
        tick();
        check2("R7 evaluated at tick", alarm_match, 2'b01);
        check2("R8 alarm0 rises", alarm_status, 2'b01);

        // R9: clear only selected bit; set beats clear
        time_now = tm(8'h01, 8'h24, 8'h06, 8'h03, 8'h21, 8'h30, 8'h00);
        tick();
        check2("R8 alarm1 rises", alarm_status, 2'b11);
        stat_wr = 1'b1; stat_clr = 2'b01;
        @(negedge clk);
        stat_wr = 1'b0; stat_clr = 2'b00;
        check2("R9 selective clear", alarm_status, 2'b10);
        time_now = '0;
        tick();
        clear_all();
        time_now = tm(8'h01, 8'h24, 8'h06, 8'h03, 8'h21, 8'h30, 8'h00);
        stat_wr = 1'b1; stat_clr = 2'b10; sec_tick = 1'b1;
        @(negedge clk);
        stat_wr = 1'b0; stat_clr = 2'b00; sec_tick = 1'b0;
        check2("R9 set wins over clear", alarm_status, 2'b10);

        // R6 yearly on alarm 1; R1 alarm 0 untouched
        wr_field(1'b1, 3'd4, 8'h12, 1'b1);
        wr_field(1'b1, 3'd3, 8'h25, 1'b1);
        wr_field(1'b1, 3'd2, 8'h07, 1'b1);
        wr_field(1'b1, 3'd1, 8'h15, 1'b1);
        time_now = tm(8'h03, 8'h30, 8'h12, 8'h25, 8'h07, 8'h15, 8'h00);
        tick();
        check2("R6 yearly match", alarm_match, 2'b10);
        time_now = tm(8'h03, 8'h30, 8'h11, 8'h25, 8'h07, 8'h15, 8'h00);
        tick();
        check2("R6 wrong month", alarm_match, 2'b00);
        time_now = tm(8'h03, 8'h30, 8'h11, 8'h25, 8'h08, 8'h00, 8'h00);
        tick();
        check2("R1 alarm0 unaffected by alarm1 writes", alarm_match, 2'b01);

        // R2: clearing every enable of alarm 1 stops it
        for (int f = 0; f < 7; f++) wr_field(1'b1, 3'(f), 8'h00, 1'b0);
        time_now = '0;
        tick();
        check2("R2 disabled alarm1 silent", alarm_match, 2'b00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule